// File: doc/BRIEF.md
# UART Word Bridge for a Device Under Test

This block sits between a serial UART line and a device under test. On the inbound side it decodes serial bytes. It groups every three good bytes into one transaction and presents a 16-bit input word to the device through a valid/ready pair. On the outbound side it accepts a 20-bit result word through a second valid/ready pair. It widens that word to 24 bits with zeros and shifts it out as three serial bytes.

Both serial directions use one start bit (low), eight data bits least significant first, and one stop bit (high). The idle line is high. Every bit lasts ten system clocks. The serial input is synchronized before any sampling takes place. A start bit that does not hold until mid-bit is ignored. A low stop bit throws away the partly collected group.

Top module: `uart_word_bridge`

## Requirements
- R1: After reset, `tx_o` is high, `in_valid_o` is low and `res_ready_o` is high.
- R2: The receiver decodes frames of start bit 0, eight data bits sent least significant bit first, and stop bit 1, at 10 clocks per bit. The input passes through a two-flop synchronizer first.
- R3: A low pulse on `rx_i` that ends before the mid-bit check of the start bit (cycle 5 of 10) produces no byte.
- R4: A byte whose stop bit is sampled low is dropped, along with any bytes already collected for the current group. The next group is assembled from its first byte.
- R5: Three received bytes b0, b1, b2 (in arrival order) form the group {b0,b1,b2}. `in_word_o` equals {b1,b2}, and b0 has no effect on it.
- R6: While `in_valid_o` is high and `in_ready_i` is low, `in_valid_o` stays high and `in_word_o` stays stable.
- R7: The transmitter sends frames of start bit 0, eight data bits least significant bit first, and stop bit 1. Each bit is held for exactly 10 clocks, and the line is high when idle.
- R8: A result r is sent as three bytes in this order: {4'b0000, r[19:16]}, then r[15:8], then r[7:0].
- R9: The three bytes of one result are sent back to back: the start edges of consecutive bytes are exactly 100 clocks apart.
- R10: `res_ready_o` falls in the cycle after a result is accepted. It stays low until the stop bit of the third byte has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial input line |
| tx_o | output | 1 | Serial output line |
| in_valid_o | output | 1 | Input word available for the device |
| in_word_o | output | 16 | Input word: the low 16 bits of the received group |
| in_ready_i | input | 1 | Device accepts the input word |
| res_valid_i | input | 1 | Device offers a result word |
| res_i | input | 20 | Result word |
| res_ready_o | output | 1 | Bridge can take a new result |

## Verification
If the receive bit counter or the byte index slipped, the next group would come out as a word built from the wrong byte pair. That shows at `in_word_o` within one group time (about 300 clocks). A stuck transmit sequencer shows within one frame as a wrong bit value at a mid-bit sample, or as a gap between start edges that is not 100 clocks. A stale busy flag in the result path shows as `res_ready_o` staying low past the third stop bit.

// File: rtl/ubr_pkg.sv
package ubr_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
  typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
endpackage

// File: rtl/ubr_rx.sv
module ubr_rx
  import ubr_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 10,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              frame_err_o
);
  localparam int unsigned CNT_W = $clog2(CLKS_PER_BIT);
  localparam int unsigned HALF  = CLKS_PER_BIT / 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s, rx_prev_q;
  rx_state_e              state_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [2:0]             bit_q;
  logic [BYTE_W-1:0]      shift_q;

  assign rx_s   = sync_q[SYNC_STAGES-1];
  assign byte_o = shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q    <= '1;
      rx_prev_q <= 1'b1;
    end else begin
      sync_q    <= {sync_q[SYNC_STAGES-2:0], rx_i};
      rx_prev_q <= rx_s;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= RX_IDLE;
      cnt_q        <= '0;
      bit_q        <= '0;
      shift_q      <= '0;
      byte_valid_o <= 1'b0;
      frame_err_o  <= 1'b0;
    end else begin
      byte_valid_o <= 1'b0;
      frame_err_o  <= 1'b0;
      case (state_q)
        RX_IDLE: begin
          if (rx_prev_q && !rx_s) begin
            state_q <= RX_START;
            cnt_q   <= '0;
          end
        end
        RX_START: begin
          // mid-bit recheck rejects glitches
          if (cnt_q == CNT_W'(HALF - 1)) begin
            cnt_q <= '0;
            bit_q <= '0;
            state_q <= rx_s ? RX_IDLE : RX_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == CNT_W'(CLKS_PER_BIT - 1)) begin
            cnt_q   <= '0;
            shift_q <= {rx_s, shift_q[BYTE_W-1:1]};
            bit_q   <= bit_q + 1'b1;
            if (bit_q == 3'd7) state_q <= RX_STOP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          if (cnt_q == CNT_W'(CLKS_PER_BIT - 1)) begin
            cnt_q   <= '0;
            state_q <= RX_IDLE;
            if (rx_s) byte_valid_o <= 1'b1;
            else      frame_err_o  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  AST_RX_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o); // R2
  AST_RX_GLITCH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_START && rx_s && cnt_q == CNT_W'(HALF - 1)) |=> state_q == RX_IDLE); // R3
endmodule

// File: rtl/ubr_tx.sv
module ubr_tx
  import ubr_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              ready_o,
  output logic              tx_o
);
  localparam int unsigned CNT_W = $clog2(CLKS_PER_BIT);

  tx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [2:0]        bit_q;
  logic [BYTE_W-1:0] shift_q;
  logic              last_cyc;

  assign last_cyc = (cnt_q == CNT_W'(CLKS_PER_BIT - 1));
  // accept next byte in the last stop cycle so frames abut
  assign ready_o  = (state_q == TX_IDLE) || (state_q == TX_STOP && last_cyc);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      tx_o    <= 1'b1;
    end else if (start_i && ready_o) begin
      state_q <= TX_START;
      cnt_q   <= '0;
      shift_q <= data_i;
      tx_o    <= 1'b0;
    end else begin
      case (state_q)
        TX_START: begin
          if (last_cyc) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            tx_o    <= shift_q[0];
            state_q <= TX_DATA;
          end else cnt_q <= cnt_q + 1'b1;
        end
        TX_DATA: begin
          if (last_cyc) begin
            cnt_q <= '0;
            if (bit_q == 3'd7) begin
              tx_o    <= 1'b1;
              state_q <= TX_STOP;
            end else begin
              bit_q   <= bit_q + 1'b1;
              shift_q <= shift_q >> 1;
              tx_o    <= shift_q[1];
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        TX_STOP: begin
          if (last_cyc) begin
            cnt_q   <= '0;
            state_q <= TX_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  AST_TX_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o) |=> !tx_o); // R7
  AST_TX_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_IDLE) |-> tx_o); // R7
endmodule

// File: rtl/ubr_pack.sv
module ubr_pack
  import ubr_pkg::*;
#(
  parameter int unsigned BYTES = 3,
  parameter int unsigned IN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              frame_err_i,
  output logic              in_valid_o,
  output logic [IN_W-1:0]   in_word_o,
  input  logic              in_ready_i
);
  localparam int unsigned GRP_W = BYTES * BYTE_W;
  localparam int unsigned IDX_W = $clog2(BYTES + 1);

  logic [GRP_W-1:0] grp_q, grp_next;
  logic [IDX_W-1:0] idx_q;
  logic             grp_done;

  generate
    if (BYTES > 1) begin : g_shift
      assign grp_next = {grp_q[GRP_W-BYTE_W-1:0], byte_i};
    end else begin : g_single
      assign grp_next = byte_i;
    end
  endgenerate

  assign grp_done = byte_valid_i && !frame_err_i && (idx_q == IDX_W'(BYTES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_q      <= '0;
      idx_q      <= '0;
      in_valid_o <= 1'b0;
      in_word_o  <= '0;
    end else begin
      if (frame_err_i) begin
        idx_q <= '0;
      end else if (byte_valid_i) begin
        grp_q <= grp_next;
        idx_q <= grp_done ? '0 : idx_q + 1'b1;
      end
      if (in_valid_o && in_ready_i) in_valid_o <= 1'b0;
      if (grp_done) begin
        in_valid_o <= 1'b1;
        in_word_o  <= grp_next[IN_W-1:0];
      end
    end
  end

  AST_IN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_o && !in_ready_i && !grp_done) |=> (in_valid_o && $stable(in_word_o))); // R6
  AST_ERR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_i |=> (idx_q == '0)); // R4
endmodule

// File: rtl/ubr_unpack.sv
module ubr_unpack
  import ubr_pkg::*;
#(
  parameter int unsigned BYTES = 3,
  parameter int unsigned RES_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              res_valid_i,
  input  logic [RES_W-1:0]  res_i,
  output logic              res_ready_o,
  input  logic              tx_ready_i,
  output logic              tx_start_o,
  output logic [BYTE_W-1:0] tx_byte_o
);
  localparam int unsigned GRP_W = BYTES * BYTE_W;
  localparam int unsigned IDX_W = $clog2(BYTES + 1);

  logic [GRP_W-1:0] sr_q;
  logic [IDX_W-1:0] sent_q;
  logic             active_q;
  logic             all_sent;

  assign all_sent    = (sent_q == IDX_W'(BYTES));
  assign res_ready_o = !active_q;
  assign tx_start_o  = active_q && tx_ready_i && !all_sent;
  assign tx_byte_o   = sr_q[GRP_W-1 -: BYTE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q     <= '0;
      sent_q   <= '0;
      active_q <= 1'b0;
    end else if (res_valid_i && res_ready_o) begin
      sr_q     <= GRP_W'(res_i);
      sent_q   <= '0;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (tx_start_o) begin
        sr_q   <= sr_q << BYTE_W;
        sent_q <= sent_q + 1'b1;
      end else if (all_sent && tx_ready_i) begin
        // last stop bit is in its final cycle
        active_q <= 1'b0;
      end
    end
  end

  AST_RES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_ready_o) |=> !res_ready_o); // R10
  AST_RES_BUSY_UNTIL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!res_ready_o && !tx_ready_i) |=> !res_ready_o); // R10
endmodule

// File: rtl/uart_word_bridge.sv
module uart_word_bridge
  import ubr_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 10,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned BYTES        = 3,
  parameter int unsigned IN_W         = 16,
  parameter int unsigned RES_W        = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  output logic             tx_o,
  output logic             in_valid_o,
  output logic [IN_W-1:0]  in_word_o,
  input  logic             in_ready_i,
  input  logic             res_valid_i,
  input  logic [RES_W-1:0] res_i,
  output logic             res_ready_o
);
  logic              rx_valid, rx_err;
  logic [BYTE_W-1:0] rx_byte;
  logic              tx_ready, tx_start;
  logic [BYTE_W-1:0] tx_byte;

  ubr_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk_i, .rst_ni, .rx_i,
    .byte_valid_o(rx_valid), .byte_o(rx_byte), .frame_err_o(rx_err)
  );

  ubr_pack #(.BYTES(BYTES), .IN_W(IN_W)) u_pack (
    .clk_i, .rst_ni,
    .byte_valid_i(rx_valid), .byte_i(rx_byte), .frame_err_i(rx_err),
    .in_valid_o, .in_word_o, .in_ready_i
  );

  ubr_unpack #(.BYTES(BYTES), .RES_W(RES_W)) u_unpack (
    .clk_i, .rst_ni, .res_valid_i, .res_i, .res_ready_o,
    .tx_ready_i(tx_ready), .tx_start_o(tx_start), .tx_byte_o(tx_byte)
  );

  ubr_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk_i, .rst_ni,
    .start_i(tx_start), .data_i(tx_byte), .ready_o(tx_ready), .tx_o
  );

  AST_TX_IDLE_WHEN_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_ready_o && tx_ready) |-> tx_o); // R1
endmodule

// File: tb/uart_word_bridge_bench.sv
module uart_word_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx = 1'b1;
  logic        in_ready = 1'b1;
  logic        res_valid = 1'b0;
  logic [19:0] res = '0;
  logic        tx, in_valid, res_ready;
  logic [15:0] in_word;

  always #4 clk = ~clk;

  uart_word_bridge u_uart_word_bridge (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tx_o(tx),
    .in_valid_o(in_valid), .in_word_o(in_word), .in_ready_i(in_ready),
    .res_valid_i(res_valid), .res_i(res), .res_ready_o(res_ready)
  );

  int unsigned cyc = 0;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] exp_in_q[$];
  logic [7:0]  exp_tx_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rx = b;
    repeat (10) @(posedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic stop);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    send_bit(stop);
    if (!stop) send_bit(1'b1);
  endtask

  // driver: expected word is {b1,b2}
  task automatic send_group(input logic [7:0] b0, b1, b2);
    exp_in_q.push_back({b1, b2});
    send_byte(b0, 1'b1);
    send_byte(b1, 1'b1);
    send_byte(b2, 1'b1);
  endtask

  task automatic drive_res(input logic [19:0] r);
    @(negedge clk);
    while (!res_ready) @(negedge clk);
    exp_tx_q.push_back({4'h0, r[19:16]});
    exp_tx_q.push_back(r[15:8]);
    exp_tx_q.push_back(r[7:0]);
    res_valid = 1'b1;
    res = r;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  // monitor: input words
  always @(negedge clk) begin
    if (rst_n && in_valid && in_ready) begin
      if (exp_in_q.size() == 0) chk(1'b0, "R5 unexpected word", in_word, 0);
      else begin
        logic [15:0] e;
        e = exp_in_q.pop_front();
        chk(in_word == e, "R5 input word", in_word, e);
      end
    end
  end

  // monitor: serial output
  initial begin
    int unsigned start_c, last_c;
    int idx;
    logic [7:0] d;
    idx = 0;
    last_c = 0;
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (tx === 1'b0) begin
        start_c = cyc;
        repeat (5) @(negedge clk);
        chk(tx == 1'b0, "R7 start bit", tx, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (10) @(negedge clk);
          d[i] = tx;
        end
        repeat (10) @(negedge clk);
        chk(tx == 1'b1, "R7 stop bit", tx, 1);
        if (idx % 3 != 0) chk(start_c - last_c == 100, "R9 byte spacing", start_c - last_c, 100);
        last_c = start_c;
        idx++;
        if (exp_tx_q.size() == 0) chk(1'b0, "R8 unexpected byte", d, 0);
        else begin
          logic [7:0] e;
          e = exp_tx_q.pop_front();
          chk(d == e, "R8 output byte", d, e);
        end
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx == 1'b1, "R1 tx idle", tx, 1);
    chk(in_valid == 1'b0, "R1 in_valid", in_valid, 0);
    chk(res_ready == 1'b1, "R1 res_ready", res_ready, 1);

    // R2 R5: several patterns, first byte ignored
    send_group(8'h12, 8'hAB, 8'hCD);
    send_group(8'h34, 8'h00, 8'h01);
    send_group(8'hFF, 8'hFF, 8'hFF);
    send_group(8'h00, 8'h80, 8'h7E);

    // R3: short low glitch
    @(posedge clk);
    rx = 1'b0;
    repeat (3) @(posedge clk);
    rx = 1'b1;
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk(in_valid == 1'b0, "R3 glitch no word", in_valid, 0);
    send_group(8'h00, 8'h5A, 8'hA5);

    // R4: framing error drops partial group
    send_byte(8'h77, 1'b1);
    send_byte(8'h88, 1'b0);
    @(negedge clk);
    chk(in_valid == 1'b0, "R4 no word after error", in_valid, 0);
    send_group(8'h01, 8'hC3, 8'h3C);

    // R6: hold while not ready
    in_ready = 1'b0;
    send_group(8'h09, 8'hBE, 8'hEF);
    @(negedge clk);
    chk(in_valid == 1'b1, "R6 valid held", in_valid, 1);
    chk(in_word == 16'hBEEF, "R6 word held", in_word, 16'hBEEF);
    repeat (50) @(negedge clk);
    chk(in_valid == 1'b1, "R6 valid still held", in_valid, 1);
    chk(in_word == 16'hBEEF, "R6 word still held", in_word, 16'hBEEF);
    in_ready = 1'b1;
    repeat (3) @(negedge clk);

    // R7 R8 R9 R10: results
    drive_res(20'hABCDE);
    chk(res_ready == 1'b0, "R10 busy after accept", res_ready, 0);
    repeat (290) @(negedge clk);
    chk(res_ready == 1'b0, "R10 busy before last stop ends", res_ready, 0);
    repeat (15) @(negedge clk);
    chk(res_ready == 1'b1, "R10 ready after last stop", res_ready, 1);
    drive_res(20'hFFFFF);
    drive_res(20'h00000);
    drive_res(20'h12345);

    for (int i = 0; i < 2000 && (exp_tx_q.size() != 0 || exp_in_q.size() != 0); i++)
      @(negedge clk);
    repeat (50) @(negedge clk);
    chk(exp_tx_q.size() == 0, "R8 all bytes sent", exp_tx_q.size(), 0);
    chk(exp_in_q.size() == 0, "R5 all words seen", exp_in_q.size(), 0);
    finish_run();
  end
endmodule